// File: doc/BRIEF.md
# Serial Load and Readback Port for a Converter Code Register

This block holds the 8-bit code that sets a converter and lets a host change it over a three-pin serial link: an active-low select, a shift clock and a data input. A three-state data output returns the code that was held before the transfer began. While the select is low, the new code enters most-significant bit first on rising shift-clock edges. Over the same edges, the old code leaves on the falling edges. When the select rises, the received word becomes the new code. The code drives a parallel output that feeds the converter.

The pins are asynchronous to the block. They pass through two-flop synchronisers, and their edges are found on the system clock. The system clock must run at least 8 times faster than the shift clock, and the shift clock runs at 2 MHz at most. Until the first select low after reset, a pulse-mode controller may write the code through a strobe and data input. From that first select low on, the interface stays in three-wire mode until the next reset, and pulse writes are refused. A shutdown input freezes the code register.

Top module: `serial_code_port`

## Requirements
- R1: Reset is synchronous and active low. After reset the code output reads 0x80 (mid-scale), the data-out enable is low and the three-wire mode flag is low.
- R2: A falling select, seen on the third clock edge after the pin changes, raises the data-out enable. A rising select lowers it with the same latency.
- R3: The data input is sampled on each rising shift-clock edge, and the first bit sampled is the most significant.
- R4: When the select falls, data-out shows the MSB of the held code. It moves on by one bit on each falling shift-clock edge. Through a 9-bit shift path, after 8 old bits data-out continues with the first bits received in this transfer.
- R5: When the select rises, the code takes the low 8 bits of the stream formed by the old code followed by every bit received. For exactly 8 bits this is the received word. For any other count, the last 8 bits of that stream are committed.
- R6: The first select fall after reset sets the three-wire mode flag. The flag stays set until the next reset.
- R7: A pulse write (strobe high for one clock, with code data) loads the code only while the mode flag is low and shutdown is low.
- R8: While shutdown is high, the code does not change. A commit at the end of a transfer and a pulse write are both discarded, but readback still works.
- R9: A falling shift-clock edge shifts data-out only if a rising edge was sampled after the previous shift. A falling edge at the start of a transfer therefore leaves the MSB of the old code on data-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the shift clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Asynchronous select, active low |
| sck_i | input | 1 | Asynchronous shift clock |
| sdi_i | input | 1 | Asynchronous serial data in |
| sleep_i | input | 1 | Shutdown, high freezes the code register |
| pulse_we_i | input | 1 | Write strobe from pulse-mode logic |
| pulse_code_i | input | 8 | Code offered by pulse-mode logic |
| code_o | output | 8 | Held converter code |
| sdo_o | output | 1 | Serial readback bit, low when not driven |
| sdo_oe_o | output | 1 | Data-out drive enable, low means high impedance |
| three_wire_mode_o | output | 1 | Set once the interface has locked to three-wire mode |

## Verification
Assertions check on every cycle that the mode flag never clears and that the enable is only high once the mode is locked. They also check that shutdown and the lock freeze the code against late commits and pulse writes. They cover the reset value of 0x80, the MSB of the old code appearing when the select falls, and a falling edge that has no sample behind it shifting nothing. Only the bench scenarios can show the full order of bits: the old code read back while a new one enters, and the committed value for transfers of 5, 8 and 11 bits. They also show a transfer that opens with the shift clock high, and the return to pulse-write acceptance after a second reset.

// File: rtl/code_port_pkg.sv
// Package: shared pin indices for the serial code port.
// Assumes the three serial pins are carried together as one vector.
package code_port_pkg;
    localparam int PIN_CS    = 0;
    localparam int PIN_SCK   = 1;
    localparam int PIN_SDI   = 2;
    localparam int PIN_COUNT = 3;
    // Idle levels: select high, clock and data low.
    localparam logic [PIN_COUNT-1:0] PIN_IDLE = 3'b001;
endpackage

// File: rtl/pin_sync.sv
// pin_sync: multi-stage synchroniser with edge detection for a bundle of
// asynchronous pins. The synchronised level appears SYNC_STAGES edges
// after a pin change, and edges are flagged one cycle wide in that same
// cycle. Assumes each pin holds stable for more than SYNC_STAGES+1 clocks.
module pin_sync #(
    parameter int                 N_PINS      = 3,
    parameter int                 SYNC_STAGES = 2,
    parameter logic [N_PINS-1:0]  RESET_VAL   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_i,
    output logic [N_PINS-1:0] level_o,
    output logic [N_PINS-1:0] rise_o,
    output logic [N_PINS-1:0] fall_o
);
    logic [N_PINS-1:0] stage_q [SYNC_STAGES];
    logic [N_PINS-1:0] prev_q;

    // Move pins through the synchroniser chain and keep last synced level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) stage_q[i] <= RESET_VAL;
            prev_q <= RESET_VAL;
        end else begin
            stage_q[0] <= pin_i;
            for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
            prev_q <= stage_q[SYNC_STAGES-1];
        end
    end

    // Compare synced level with previous one to flag edges.
    always_comb begin
        level_o = stage_q[SYNC_STAGES-1];
        rise_o  = level_o & ~prev_q;
        fall_o  = ~level_o & prev_q;
    end
endmodule

// File: rtl/shift_engine.sv
// shift_engine: the 9-bit serial path for one transfer. On select start
// it loads the held code behind the output end, then takes a data bit
// into the input end on each clock rise and shifts toward the output on
// the next clock fall. A fall with no rise before it shifts nothing. On
// select end it offers the last CODE_W bits received, with a strobe.
// Assumes the select and shift-clock edges never fall in the same cycle.
module shift_engine #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_start,
    input  logic              sel_end,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              sdi_lvl,
    input  logic [CODE_W-1:0] load_code,
    output logic              sdo_bit,
    output logic              active_o,
    output logic              commit_stb,
    output logic [CODE_W-1:0] commit_word
);
    localparam int PATH_W = CODE_W + 1;

    logic [PATH_W-1:0] path_q;
    logic              active_q;
    logic              armed_q;

    // Load, sample and shift the serial path during a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            path_q   <= '0;
            active_q <= 1'b0;
            armed_q  <= 1'b0;
        end else if (sel_start) begin
            path_q   <= {load_code, 1'b0};
            active_q <= 1'b1;
            armed_q  <= 1'b0;
        end else if (sel_end) begin
            active_q <= 1'b0;
            armed_q  <= 1'b0;
        end else if (active_q) begin
            if (sck_rise) begin
                path_q[0] <= sdi_lvl;
                armed_q   <= 1'b1;
            end else if (sck_fall && armed_q) begin
                path_q  <= {path_q[PATH_W-2:0], 1'b0};
                armed_q <= 1'b0;
            end
        end
    end

    // Pick the newest CODE_W bits depending on a pending sample.
    always_comb begin
        sdo_bit     = path_q[PATH_W-1];
        active_o    = active_q;
        commit_stb  = sel_end & active_q;
        commit_word = armed_q ? path_q[CODE_W-1:0] : path_q[PATH_W-1:1];
    end

    AST_END_RELEASES_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_end |=> !active_q); // R2
    AST_START_SHOWS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        sel_start |=> (sdo_bit == $past(load_code[CODE_W-1]))); // R4
    AST_FALL_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !armed_q && sck_fall && !sel_end && !sel_start) |=> $stable(path_q)); // R9
endmodule

// File: rtl/code_store.sv
// code_store: the converter code register and the three-wire mode lock.
// A serial commit or a pulse write updates the code unless shutdown is
// high. Pulse writes are refused once the lock is set, and the lock
// clears only on reset. Assumes commit strobes arrive only after locking.
module code_store #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_req,
    input  logic              commit_stb,
    input  logic [CODE_W-1:0] commit_word,
    input  logic              pulse_we,
    input  logic [CODE_W-1:0] pulse_code,
    input  logic              sleep,
    output logic [CODE_W-1:0] code_q,
    output logic              locked_q
);
    localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

    // Set the sticky three-wire lock on the first select fall.
    always_ff @(posedge clk) begin
        if (!rst_n)        locked_q <= 1'b0;
        else if (lock_req) locked_q <= 1'b1;
    end

    // Update the code from a commit or an allowed pulse write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= MID_CODE;
        end else if (!sleep) begin
            if (commit_stb)                code_q <= commit_word;
            else if (pulse_we && !locked_q) code_q <= pulse_code;
        end
    end

    AST_MID_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> (code_q == MID_CODE)); // R1
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> locked_q); // R6
    AST_HOLD_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> $stable(code_q)); // R8
    AST_PULSE_LOCKED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && pulse_we && !commit_stb) |=> $stable(code_q)); // R7
endmodule

// File: rtl/serial_code_port.sv
// serial_code_port: top of the serial load and readback port. Joins the
// pin synchroniser, the 9-bit shift engine and the code store. Assumes
// clk runs at least 8x the shift clock. Data-out is returned as a value
// plus a drive enable, so the three-state buffer sits at the pad.
module serial_code_port #(
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sck_i,
    input  logic              sdi_i,
    input  logic              sleep_i,
    input  logic              pulse_we_i,
    input  logic [CODE_W-1:0] pulse_code_i,
    output logic [CODE_W-1:0] code_o,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              three_wire_mode_o
);
    import code_port_pkg::*;

    logic [PIN_COUNT-1:0] pin_vec, pin_lvl, pin_rise, pin_fall;
    logic                 sel_start, sel_end;
    logic                 sdo_raw, active;
    logic                 commit_stb;
    logic [CODE_W-1:0]    commit_word;
    logic [CODE_W-1:0]    code_q;
    logic                 locked_q;
    logic                 unused_edges;

    // Bundle the pins and decode the select edges.
    always_comb begin
        pin_vec[PIN_CS]  = cs_n_i;
        pin_vec[PIN_SCK] = sck_i;
        pin_vec[PIN_SDI] = sdi_i;
        sel_start        = pin_fall[PIN_CS];
        sel_end          = pin_rise[PIN_CS];
        unused_edges     = pin_rise[PIN_SDI] ^ pin_fall[PIN_SDI]
                         ^ pin_lvl[PIN_CS] ^ pin_lvl[PIN_SCK];
    end

    pin_sync #(
        .N_PINS      (PIN_COUNT),
        .SYNC_STAGES (SYNC_STAGES),
        .RESET_VAL   (PIN_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_vec),
        .level_o (pin_lvl),
        .rise_o  (pin_rise),
        .fall_o  (pin_fall)
    );

    shift_engine #(.CODE_W(CODE_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_start   (sel_start),
        .sel_end     (sel_end),
        .sck_rise    (pin_rise[PIN_SCK]),
        .sck_fall    (pin_fall[PIN_SCK]),
        .sdi_lvl     (pin_lvl[PIN_SDI]),
        .load_code   (code_q),
        .sdo_bit     (sdo_raw),
        .active_o    (active),
        .commit_stb  (commit_stb),
        .commit_word (commit_word)
    );

    code_store #(.CODE_W(CODE_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .lock_req    (sel_start),
        .commit_stb  (commit_stb),
        .commit_word (commit_word),
        .pulse_we    (pulse_we_i),
        .pulse_code  (pulse_code_i),
        .sleep       (sleep_i),
        .code_q      (code_q),
        .locked_q    (locked_q)
    );

    // Drive the outputs, holding data-out low while not enabled.
    always_comb begin
        code_o            = code_q;
        sdo_oe_o          = active;
        sdo_o             = active & sdo_raw;
        three_wire_mode_o = locked_q;
    end

    AST_DRIVE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe_o |-> three_wire_mode_o); // R2
endmodule

// File: tb/serial_code_port_tb.sv
// Bench for serial_code_port: a behavioural reference model, compared on
// every clock, plus directed scenarios with explicit checks.
module serial_code_port_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, sleep = 1'b0, pulse_we = 1'b0;
    logic [W-1:0] pulse_code = '0;
    logic [W-1:0] code;
    logic         sdo, sdo_oe, mode;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int exp_code = 128;

    always #5 clk = ~clk;

    serial_code_port #(.CODE_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .sdi_i(sdi),
        .sleep_i(sleep), .pulse_we_i(pulse_we), .pulse_code_i(pulse_code),
        .code_o(code), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .three_wire_mode_o(mode)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model: pin delay line, bit stream queue and read pointer.
    logic [2:0] m_s1, m_s2, m_prev;
    int  m_code, m_ptr, m_old;
    bit  m_locked, m_active, m_pending, m_valid;
    bit  m_stream[$];
    bit  csf, csr, skr, skf;

    function automatic int last8();
        int v = 0;
        int n = m_stream.size();
        for (int i = 0; i < W; i++) v = (v << 1) | int'(m_stream[n-W+i]);
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 3'b001; m_s2 = 3'b001; m_prev = 3'b001;
            m_code = 128; m_locked = 0; m_active = 0; m_pending = 0;
            m_ptr = 0; m_stream.delete(); m_valid = 1;
        end else begin
            csf = m_prev[0] && !m_s2[0];
            csr = !m_prev[0] && m_s2[0];
            skr = !m_prev[1] && m_s2[1];
            skf = m_prev[1] && !m_s2[1];
            m_old = m_code;
            if (!sleep) begin
                if (csr && m_active)              m_code = last8();
                else if (pulse_we && !m_locked)   m_code = int'(pulse_code);
            end
            if (csf) begin
                m_locked = 1; m_active = 1; m_pending = 0; m_ptr = 0;
                m_stream.delete();
                for (int i = W-1; i >= 0; i--) m_stream.push_back(m_old[i]);
            end else if (csr) begin
                m_active = 0; m_pending = 0;
            end else if (m_active) begin
                if (skr) begin
                    m_stream.push_back(m_s2[2]); m_pending = 1;
                end else if (skf && m_pending) begin
                    m_ptr++; m_pending = 0;
                end
            end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = {sdi, sck, cs_n};
        end
    end

    // Compare the design with the model on every clock.
    always @(negedge clk) begin
        if (rst_n && m_valid && !finished) begin
            check("R5 code vs model", 32'(code), 32'(m_code));
            check("R2 sdo_oe vs model", 32'(sdo_oe), 32'(m_active));
            check("R6 mode vs model", 32'(mode), 32'(m_locked));
            if (m_active) check("R4 sdo vs model", 32'(sdo), 32'(m_stream[m_ptr]));
        end
    end

    task automatic pulse_write(input logic [W-1:0] v);
        @(negedge clk); pulse_code = v; pulse_we = 1'b1;
        @(negedge clk); pulse_we = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // One transfer of n bits; checks readback and committed code.
    task automatic run_xfer(input int data, input int n, input bit sck_hi, input bit asleep,
                            input string tag);
        int stream, exp_rb, exp_new;
        int rb = 0;
        stream  = (exp_code << n) | data;
        exp_rb  = (stream >> W) & ((1 << n) - 1);
        exp_new = asleep ? exp_code : (stream & 8'hFF);
        @(negedge clk); sleep = asleep; sck = sck_hi;
        repeat (4) @(negedge clk);
        cs_n = 1'b0;
        repeat (8) @(negedge clk);
        if (sck_hi) begin sck = 1'b0; repeat (4) @(negedge clk); end
        for (int i = 0; i < n; i++) begin
            sdi = data[n-1-i];
            repeat (4) @(negedge clk);
            rb = (rb << 1) | int'(sdo);
            sck = 1'b1; repeat (4) @(negedge clk);
            sck = 1'b0; repeat (4) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
        check({tag, " readback"}, 32'(rb), 32'(exp_rb));
        check({tag, " committed code"}, 32'(code), 32'(exp_new));
        check("R2 data-out released", 32'(sdo_oe), 32'd0);
        sleep = 1'b0;
        exp_code = exp_new;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (5) @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        exp_code = 128;
        check("R1 code after reset", 32'(code), 32'h80);
        check("R1 sdo_oe after reset", 32'(sdo_oe), 32'd0);
        check("R1 mode after reset", 32'(mode), 32'd0);
    endtask

    initial begin
        do_reset();
        pulse_write(8'h3C); exp_code = 'h3C;
        check("R7 pulse write before lock", 32'(code), 32'h3C);
        sleep = 1'b1; pulse_write(8'h44); sleep = 1'b0;
        check("R8 pulse write in shutdown", 32'(code), 32'h3C);
        run_xfer('hA5, 8, 0, 0, "R3 R4 R5 eight bits");
        check("R6 locked after transfer", 32'(mode), 32'd1);
        pulse_write(8'h11);
        check("R7 pulse write after lock", 32'(code), 32'hA5);
        run_xfer('h16, 5, 0, 0, "R5 five bits");
        run_xfer('h5C3, 11, 0, 0, "R4 R5 eleven bits");
        run_xfer('h69, 8, 1, 0, "R9 clock high at select");
        run_xfer('h0F, 8, 0, 1, "R8 commit in shutdown");
        run_xfer('hF0, 8, 0, 0, "R4 readback after shutdown");
        check("R6 still locked", 32'(mode), 32'd1);
        do_reset();
        pulse_write(8'h20); exp_code = 'h20;
        check("R6 R7 pulse accepted after second reset", 32'(code), 32'h20);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule